// File: doc/BRIEF.md
# Multidrop PHY Link and Interrupt Register Set

This block is the management-side register file of a 10BASE-T1S multidrop PHY. A host reaches it through a plain parallel register port with a 5-bit address and 16-bit data. Reads and writes are single-cycle strobes, and read data is returned on the clock edge after the request. The register file holds the link-enable control, a link status word, a transmit-opportunity timer setting for the PLCA engine, and an interrupt pair made of a per-source enable mask and a pending-event word that clears when it is read.

The PHY core feeds the block two levels, live link state and PLCA state, and four one-cycle event pulses: local jabber, remote jabber, PLCA recovery and physical collision. The block turns an edge on either level into a change event. It collects every event into the pending word and drives an active-high interrupt line whenever a pending event is also enabled. The link bit in the status word is latch-low, so a host that polls slowly still sees a momentary link drop. The PHY has no auto-negotiation, so the link-enable control occupies the bit position normally used for auto-negotiation enable.

Top module: `t1s_mgmt_regs`

## Requirements
- R1: A synchronous active-high reset clears the control register, the interrupt enables and the pending events, forces the latched link bit to 0 and loads the timer setting with 32. On the first clock after reset is released, pending bit 15 (reset complete) is set.
- R2: Address 0 is the control register. Its only storage bit is bit 12 (link enable), which drives the `linkEnable` output. Every other bit reads as 0.
- R3: Bit 5 of the status register at address 1 is latch-low. While `linkUp` is low the latch clears. A status read returns the latched value and then reloads the latch from `linkUp`.
- R4: Bit 2 of the status register returns the live AND of `linkUp` and `plcaUp` sampled on the read cycle. All other status bits read as 0.
- R5: The pending register at address 17 collects events whether they are enabled or not. Bit 0 is set by any edge of `linkUp`, bit 1 by any edge of `plcaUp`, bit 2 by local jabber, bit 3 by remote jabber, bit 4 by PLCA recovery, bit 5 by physical collision and bit 15 by reset complete.
- R6: A read of address 17 returns the pending bits and clears them in the same access.
- R7: An event that arrives in the same cycle as a read of address 17 is not lost and remains pending after the read.
- R8: The enable register at address 16 stores only bits 0 to 5 and bit 15. `irqOut` is high exactly when some pending bit has its enable bit set, so writing 0 to address 16 masks every source.
- R9: Address 20 holds the transmit-opportunity timer setting in bits 7:0. It is readable and writable, and the `toTimer` output presents it.
- R10: Writes to the status register, the pending register or any unmapped address change nothing. A read of an unmapped address returns 0. Read data appears on the clock after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regAddr | input | 5 | Register address |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 16 | Write data |
| regRdEn | input | 1 | Read strobe |
| regRdData | output | 16 | Read data, valid on the clock after the read strobe |
| linkUp | input | 1 | Live link state from the PHY core |
| plcaUp | input | 1 | Live PLCA state from the PHY core |
| evtLocalJabber | input | 1 | One-cycle local jabber event |
| evtRemoteJabber | input | 1 | One-cycle remote jabber event |
| evtPlcaRecovery | input | 1 | One-cycle PLCA recovery event |
| evtCollision | input | 1 | One-cycle physical collision event |
| irqOut | output | 1 | Active-high interrupt |
| linkEnable | output | 1 | Link-enable control bit |
| toTimer | output | 8 | Transmit-opportunity timer setting |

## Verification
The properties assume that the event inputs are one-cycle pulses sampled on the clock and that the two level inputs change only between clock edges. Under those conditions an edge on a level can be recognised from the level's previous sampled value. The clear-on-read property holds only on cycles where no event input is active and neither level moves, so it says nothing about the collision case covered by R7. The stimulus drives every input half a period away from the active edge and releases each pulse after one cycle. It schedules the coincident read-and-event case on purpose, and keeps the levels steady across the second reset so that no level edge is mistaken for a change event.

// File: rtl/t1s_mgmt_pkg.sv
package t1s_mgmt_pkg;

  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 5'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT  = 5'd1;
  localparam logic [ADDR_W-1:0] ADDR_IRQEN = 5'd16;
  localparam logic [ADDR_W-1:0] ADDR_IRQST = 5'd17;
  localparam logic [ADDR_W-1:0] ADDR_TIMER = 5'd20;

  // bit positions decoded by host software
  localparam int CTRL_LINKEN = 12;
  localparam int STAT_LINK   = 5;
  localparam int STAT_LPLCA  = 2;

  localparam int IRQ_LINK    = 0;
  localparam int IRQ_PLCA    = 1;
  localparam int IRQ_LJAB    = 2;
  localparam int IRQ_RJAB    = 3;
  localparam int IRQ_PLCAREC = 4;
  localparam int IRQ_COLL    = 5;
  localparam int IRQ_RSTDONE = 15;

  localparam logic [DATA_W-1:0] IRQ_MASK = 16'h803F;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_STAT,
    SEL_IRQEN,
    SEL_IRQST,
    SEL_TIMER
  } regSel_e;

  typedef struct packed {
    logic    wrCtrl;
    logic    wrIrqEn;
    logic    wrTimer;
    logic    rdStat;
    logic    rdIrq;
    logic    rdEn;
    regSel_e rdSel;
  } strobes_t;

endpackage

// File: rtl/t1s_mgmt_ctrl.sv
module t1s_mgmt_ctrl
  import t1s_mgmt_pkg::*;
(
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output strobes_t          strb
);

  regSel_e addrSel;

  always_comb begin
    case (regAddr)
      ADDR_CTRL:  addrSel = SEL_CTRL;
      ADDR_STAT:  addrSel = SEL_STAT;
      ADDR_IRQEN: addrSel = SEL_IRQEN;
      ADDR_IRQST: addrSel = SEL_IRQST;
      ADDR_TIMER: addrSel = SEL_TIMER;
      default:    addrSel = SEL_NONE;
    endcase
  end

  always_comb begin
    strb         = '0;
    strb.wrCtrl  = regWrEn && (addrSel == SEL_CTRL);
    strb.wrIrqEn = regWrEn && (addrSel == SEL_IRQEN);
    strb.wrTimer = regWrEn && (addrSel == SEL_TIMER);
    strb.rdStat  = regRdEn && (addrSel == SEL_STAT);
    strb.rdIrq   = regRdEn && (addrSel == SEL_IRQST);
    strb.rdEn    = regRdEn;
    strb.rdSel   = regRdEn ? addrSel : SEL_NONE;
  end

endmodule

// File: rtl/t1s_mgmt_datapath.sv
module t1s_mgmt_datapath
  import t1s_mgmt_pkg::*;
#(
  parameter int TIMER_W   = 8,
  parameter int TIMER_RST = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  strobes_t           strb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               linkUp,
  input  logic               plcaUp,
  input  logic               evtLocalJabber,
  input  logic               evtRemoteJabber,
  input  logic               evtPlcaRecovery,
  input  logic               evtCollision,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut,
  output logic               linkEnable,
  output logic [TIMER_W-1:0] toTimer
);

  logic               ctrlLinkEn;
  logic [DATA_W-1:0]  irqEn;
  logic [DATA_W-1:0]  pend;
  logic [DATA_W-1:0]  pendNext;
  logic [DATA_W-1:0]  evtVec;
  logic [DATA_W-1:0]  rdMux;
  logic [TIMER_W-1:0] timerQ;
  logic               linkLatch;
  logic               linkPrev;
  logic               plcaPrev;
  logic               rstQ;

  // event gathering: level edges plus single-cycle pulses
  always_comb begin
    evtVec              = '0;
    evtVec[IRQ_LINK]    = linkUp ^ linkPrev;
    evtVec[IRQ_PLCA]    = plcaUp ^ plcaPrev;
    evtVec[IRQ_LJAB]    = evtLocalJabber;
    evtVec[IRQ_RJAB]    = evtRemoteJabber;
    evtVec[IRQ_PLCAREC] = evtPlcaRecovery;
    evtVec[IRQ_COLL]    = evtCollision;
    evtVec[IRQ_RSTDONE] = rstQ & ~rst;
  end

  // a read wipes old events; new ones in the same cycle survive
  always_comb begin
    pendNext = ((strb.rdIrq ? '0 : pend) | evtVec) & IRQ_MASK;
  end

  always_ff @(posedge clk) begin
    rstQ <= rst;
    if (rst) begin
      pend     <= '0;
      linkPrev <= linkUp;
      plcaPrev <= plcaUp;
    end else begin
      pend     <= pendNext;
      linkPrev <= linkUp;
      plcaPrev <= plcaUp;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlLinkEn <= 1'b0;
      irqEn      <= '0;
      timerQ     <= TIMER_W'(TIMER_RST);
    end else begin
      if (strb.wrCtrl)  ctrlLinkEn <= wrData[CTRL_LINKEN];
      if (strb.wrIrqEn) irqEn      <= wrData & IRQ_MASK;
      if (strb.wrTimer) timerQ     <= wrData[TIMER_W-1:0];
    end
  end

  // latch-low link indication
  always_ff @(posedge clk) begin
    if (rst)              linkLatch <= 1'b0;
    else if (strb.rdStat) linkLatch <= linkUp;
    else if (!linkUp)     linkLatch <= 1'b0;
  end

  always_comb begin
    rdMux = '0;
    case (strb.rdSel)
      SEL_CTRL:  rdMux[CTRL_LINKEN] = ctrlLinkEn;
      SEL_STAT: begin
        rdMux[STAT_LINK]  = linkLatch;
        rdMux[STAT_LPLCA] = linkUp & plcaUp;
      end
      SEL_IRQEN: rdMux = irqEn;
      SEL_IRQST: rdMux = pend;
      SEL_TIMER: rdMux[TIMER_W-1:0] = timerQ;
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)            rdData <= '0;
    else if (strb.rdEn) rdData <= rdMux;
  end

  assign irqOut     = |(pend & irqEn);
  assign linkEnable = ctrlLinkEn;
  assign toTimer    = timerQ;

endmodule

// File: rtl/t1s_mgmt_regs.sv
module t1s_mgmt_regs
  import t1s_mgmt_pkg::*;
#(
  parameter int TIMER_W   = 8,
  parameter int TIMER_RST = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic               regRdEn,
  output logic [DATA_W-1:0]  regRdData,
  input  logic               linkUp,
  input  logic               plcaUp,
  input  logic               evtLocalJabber,
  input  logic               evtRemoteJabber,
  input  logic               evtPlcaRecovery,
  input  logic               evtCollision,
  output logic               irqOut,
  output logic               linkEnable,
  output logic [TIMER_W-1:0] toTimer
);

  strobes_t strb;

  t1s_mgmt_ctrl uCtrl (
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  t1s_mgmt_datapath #(
    .TIMER_W   (TIMER_W),
    .TIMER_RST (TIMER_RST)
  ) uDp (
    .clk             (clk),
    .rst             (rst),
    .strb            (strb),
    .wrData          (regWrData),
    .linkUp          (linkUp),
    .plcaUp          (plcaUp),
    .evtLocalJabber  (evtLocalJabber),
    .evtRemoteJabber (evtRemoteJabber),
    .evtPlcaRecovery (evtPlcaRecovery),
    .evtCollision    (evtCollision),
    .rdData          (regRdData),
    .irqOut          (irqOut),
    .linkEnable      (linkEnable),
    .toTimer         (toTimer)
  );

endmodule

// File: rtl/t1s_mgmt_checker.sv
module t1s_mgmt_checker
  import t1s_mgmt_pkg::*;
#(
  parameter int TIMER_W   = 8,
  parameter int TIMER_RST = 32
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  regAddr,
  input logic               regWrEn,
  input logic [DATA_W-1:0]  regWrData,
  input logic               regRdEn,
  input logic [DATA_W-1:0]  regRdData,
  input logic               linkUp,
  input logic               plcaUp,
  input logic               evtLocalJabber,
  input logic               evtRemoteJabber,
  input logic               evtPlcaRecovery,
  input logic               evtCollision,
  input logic               irqOut,
  input logic               linkEnable,
  input logic [TIMER_W-1:0] toTimer
);

  logic mapped;
  logic quiet;

  assign mapped = (regAddr == ADDR_CTRL) || (regAddr == ADDR_STAT) ||
                  (regAddr == ADDR_IRQEN) || (regAddr == ADDR_IRQST) ||
                  (regAddr == ADDR_TIMER);
  assign quiet  = !evtLocalJabber && !evtRemoteJabber &&
                  !evtPlcaRecovery && !evtCollision;

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irqOut && !linkEnable));

  p_timer_default_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (toTimer == TIMER_W'(TIMER_RST)));

  p_latch_low_r3: assert property (@(posedge clk) disable iff (rst)
    (regRdEn && regAddr == ADDR_STAT && !$past(linkUp)) |=> !regRdData[STAT_LINK]);

  p_status_and_r4: assert property (@(posedge clk) disable iff (rst)
    (regRdEn && regAddr == ADDR_STAT) |=>
      (regRdData[STAT_LPLCA] == $past(linkUp && plcaUp)));

  p_clear_on_read_r6: assert property (@(posedge clk) disable iff (rst)
    (regRdEn && regAddr == ADDR_IRQST && !$past(rst) && quiet &&
     $stable(linkUp) && $stable(plcaUp)) |=> !irqOut);

  p_mask_all_r8: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regAddr == ADDR_IRQEN && regWrData == '0) |=> !irqOut);

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (regRdEn && !mapped) |=> (regRdData == '0));

endmodule

bind t1s_mgmt_regs t1s_mgmt_checker #(
  .TIMER_W   (TIMER_W),
  .TIMER_RST (TIMER_RST)
) uChk (
  .clk             (clk),
  .rst             (rst),
  .regAddr         (regAddr),
  .regWrEn         (regWrEn),
  .regWrData       (regWrData),
  .regRdEn         (regRdEn),
  .regRdData       (regRdData),
  .linkUp          (linkUp),
  .plcaUp          (plcaUp),
  .evtLocalJabber  (evtLocalJabber),
  .evtRemoteJabber (evtRemoteJabber),
  .evtPlcaRecovery (evtPlcaRecovery),
  .evtCollision    (evtCollision),
  .irqOut          (irqOut),
  .linkEnable      (linkEnable),
  .toTimer         (toTimer)
);

// File: tb/tb_t1s_mgmt_regs.sv
module tb_t1s_mgmt_regs;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic        regRdEn = 1'b0;
  logic [15:0] regRdData;
  logic        linkUp = 1'b0;
  logic        plcaUp = 1'b0;
  logic        evtLocalJabber = 1'b0;
  logic        evtRemoteJabber = 1'b0;
  logic        evtPlcaRecovery = 1'b0;
  logic        evtCollision = 1'b0;
  logic        irqOut;
  logic        linkEnable;
  logic [7:0]  toTimer;

  int checks = 0;
  int errors = 0;
  logic rdIssued = 1'b0;
  logic [15:0] expQ[$];
  string       tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  t1s_mgmt_regs dut (
    .clk (clk), .rst (rst),
    .regAddr (regAddr), .regWrEn (regWrEn), .regWrData (regWrData),
    .regRdEn (regRdEn), .regRdData (regRdData),
    .linkUp (linkUp), .plcaUp (plcaUp),
    .evtLocalJabber (evtLocalJabber), .evtRemoteJabber (evtRemoteJabber),
    .evtPlcaRecovery (evtPlcaRecovery), .evtCollision (evtCollision),
    .irqOut (irqOut), .linkEnable (linkEnable), .toTimer (toTimer)
  );

  task automatic checkVal(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: a read strobe seen at an edge is answered at that edge
  always @(posedge clk) rdIssued <= regRdEn && !rst;

  always @(negedge clk) begin
    if (rdIssued) begin
      if (expQ.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R10: read data with empty queue, actual %h expected none", regRdData);
      end else begin
        logic [15:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checkVal(t, regRdData, e);
      end
    end
  end

  task automatic writeReg(input logic [4:0] a, input logic [15:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [4:0] a, input logic [15:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    regAddr = a; regRdEn = 1'b1;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    checkVal("R1 irqOut after reset", 16'(irqOut), 16'h0);
    checkVal("R1 linkEnable after reset", 16'(linkEnable), 16'h0);
    checkVal("R9 timer default", 16'(toTimer), 16'd32);
    readReg(5'd17, 16'h8000, "R1 reset-complete pending");
    readReg(5'd17, 16'h0000, "R6 cleared after read");
    readReg(5'd16, 16'h0000, "R1 enables cleared");

    // R2 control
    writeReg(5'd0, 16'h1000);
    checkVal("R2 linkEnable set", 16'(linkEnable), 16'h1);
    readReg(5'd0, 16'h1000, "R2 control readback");
    writeReg(5'd0, 16'hFFFF);
    readReg(5'd0, 16'h1000, "R2 only bit 12 stored");
    writeReg(5'd0, 16'h0000);
    checkVal("R2 linkEnable cleared", 16'(linkEnable), 16'h0);

    // R8 / R5 link change interrupt
    writeReg(5'd16, 16'h0001);
    readReg(5'd16, 16'h0001, "R8 enable readback");
    linkUp = 1'b1;
    @(negedge clk);
    checkVal("R8 irq on enabled link change", 16'(irqOut), 16'h1);
    readReg(5'd17, 16'h0001, "R5 link change bit 0");
    checkVal("R6 irq drops after read", 16'(irqOut), 16'h0);

    // R3 latch-low, R4 AND bit
    readReg(5'd1, 16'h0000, "R3 latch still low since reset");
    readReg(5'd1, 16'h0020, "R3 live after read");
    plcaUp = 1'b1;
    @(negedge clk);
    readReg(5'd1, 16'h0024, "R4 link and plca");
    linkUp = 1'b0;
    @(negedge clk);
    linkUp = 1'b1;
    @(negedge clk);
    readReg(5'd1, 16'h0004, "R3 momentary drop latched");
    readReg(5'd1, 16'h0024, "R3 live after drop read");
    readReg(5'd17, 16'h0003, "R5 link and plca change bits");

    // R5 pulse events
    writeReg(5'd16, 16'hFFFF);
    readReg(5'd16, 16'h803F, "R8 only implemented enables");
    evtLocalJabber = 1'b1;  @(negedge clk); evtLocalJabber = 1'b0;
    evtRemoteJabber = 1'b1; @(negedge clk); evtRemoteJabber = 1'b0;
    evtPlcaRecovery = 1'b1; @(negedge clk); evtPlcaRecovery = 1'b0;
    evtCollision = 1'b1;    @(negedge clk); evtCollision = 1'b0;
    checkVal("R8 irq on pulse events", 16'(irqOut), 16'h1);
    readReg(5'd17, 16'h003C, "R5 pulse event bits");

    // R7 event coincident with read
    evtLocalJabber = 1'b1; @(negedge clk); evtLocalJabber = 1'b0;
    evtCollision = 1'b1;
    readReg(5'd17, 16'h0004, "R7 read returns older event");
    evtCollision = 1'b0;
    checkVal("R7 irq held by coincident event", 16'(irqOut), 16'h1);
    readReg(5'd17, 16'h0020, "R7 coincident event kept");
    checkVal("R6 irq low after second read", 16'(irqOut), 16'h0);

    // R8 masking, R5 collection while masked
    writeReg(5'd16, 16'h0000);
    evtRemoteJabber = 1'b1; @(negedge clk); evtRemoteJabber = 1'b0;
    checkVal("R8 masked event gives no irq", 16'(irqOut), 16'h0);
    readReg(5'd17, 16'h0008, "R5 masked event still collected");

    // R10 ignored writes and unmapped reads
    writeReg(5'd1, 16'hFFFF);
    writeReg(5'd17, 16'hFFFF);
    writeReg(5'd5, 16'hFFFF);
    readReg(5'd5, 16'h0000, "R10 unmapped read zero");
    readReg(5'd1, 16'h0024, "R10 status write ignored");
    readReg(5'd17, 16'h0000, "R10 pending write ignored");
    readReg(5'd16, 16'h0000, "R10 enables untouched");
    readReg(5'd0, 16'h0000, "R10 control untouched");

    // R9 timer
    writeReg(5'd20, 16'h0140);
    readReg(5'd20, 16'h0040, "R9 timer readback");
    checkVal("R9 timer output", 16'(toTimer), 16'h0040);

    // R1 reset mid-run
    writeReg(5'd16, 16'hFFFF);
    writeReg(5'd0, 16'h1000);
    evtCollision = 1'b1; @(negedge clk); evtCollision = 1'b0;
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    @(negedge clk);
    checkVal("R1 timer reloaded", 16'(toTimer), 16'd32);
    checkVal("R1 control cleared", 16'(linkEnable), 16'h0);
    checkVal("R1 irq low after reset", 16'(irqOut), 16'h0);
    readReg(5'd16, 16'h0000, "R1 enables cleared again");
    readReg(5'd17, 16'h8000, "R1 only reset-complete pending");
    readReg(5'd1, 16'h0004, "R1 latch cleared by reset");
    idle(2);
    finishRun();
  end

endmodule